// File: doc/BRIEF.md
# Register-access bridge from AXI4-Lite to per-region CSR ports

The bridge is the single software entry point into a set of reconfiguration register ports. It takes 32-bit reads and writes from one AXI4-Lite slave port. Each request becomes one single-beat memory-mapped command, which goes to exactly one downstream target. The target is picked by the address bits above a 2 MiB region boundary. Every downstream target shares one address, write-data and byte-enable bus. Each target has its own read strobe, write strobe, waitrequest, readdatavalid and read-data lane.

The parameter `BYTE_MODE` selects how the offset inside a region is presented downstream:
- **Word mode** (`BYTE_MODE=0`): the offset becomes a 32-bit word index and every byte enable is set.
- **Byte mode** (`BYTE_MODE=1`): the aligned byte offset passes through, and write strobes become byte enables.

Only one transaction is in flight at a time. Addresses beyond the last region are answered locally with a decode error and never reach a target.

Top module: `axil_csr_bridge`

## Requirements
- R1: Each accepted AXI read or write to a mapped region produces exactly one downstream command. The command is asserted on the read or write strobe of target index `addr[25:21]` only, and no other strobe is high at the same time.
- R2: In word mode, `dsAddr` equals `{2'b00, addr[20:2]}` and `dsBe` is `4'b1111` for reads and for writes, even when `wStrb` is partial.
- R3: In byte mode, `dsAddr` equals `{addr[20:2], 2'b00}`. For a write, `dsBe` equals the captured `wStrb`; for a read, `dsBe` is `4'b1111`.
- R4: Address bits [1:0] never influence the downstream address, enables or target.
- R5: The map has fixed region roles. Region 0 is the shared subsystem block. Regions 1-4 are ports 0-3, regions 5-8 are timestamp channels 4-7, regions 9-16 are ports 4-11, regions 17-20 are timestamp channels 16-19, and regions 21-24 are ports 12-15. Downstream index n serves region n.
- R6: An address whose region number is 25 or more raises no downstream strobe. A write to it answers `bResp=2'b11` (DECERR), and a read answers `rResp=2'b11` with `rData=0`.
- R7: At most one transaction is outstanding. A write is issued only after both its address and its data have been taken, in either order. While a B or R response is pending, no downstream strobe is high.
- R8: While the addressed target holds waitrequest high, strobe, address, byte enables and write data stay unchanged.
- R9: A read completes when the target's readdatavalid is seen (at least one cycle after the command is taken). `rData` then carries that target's read data, with `rResp=2'b00`.
- R10: A write completes in the cycle the target drops waitrequest, and it answers `bResp=2'b00`.
- R11: If a read address and write address/data are offered in the same idle cycle with no write half held, the read is taken first. `awReady` and `wReady` stay low in that cycle, and the write follows after the read response.
- R12: `bValid` and `rValid` and their payloads stay stable until `bReady` or `rReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| awAddr | input | ADDR_W | Write byte address |
| awValid | input | 1 | Write address valid |
| awReady | output | 1 | Write address ready |
| wData | input | DATA_W | Write data |
| wStrb | input | DATA_W/8 | Write byte strobes |
| wValid | input | 1 | Write data valid |
| wReady | output | 1 | Write data ready |
| bResp | output | 2 | Write response (00 okay, 11 decode error) |
| bValid | output | 1 | Write response valid |
| bReady | input | 1 | Write response ready |
| arAddr | input | ADDR_W | Read byte address |
| arValid | input | 1 | Read address valid |
| arReady | output | 1 | Read address ready |
| rData | output | DATA_W | Read data |
| rResp | output | 2 | Read response (00 okay, 11 decode error) |
| rValid | output | 1 | Read response valid |
| rReady | input | 1 | Read response ready |
| dsAddr | output | OFF_W | Shared downstream address (word or byte form) |
| dsWdata | output | DATA_W | Shared downstream write data |
| dsBe | output | DATA_W/8 | Shared downstream byte enables |
| dsWrite | output | N_TARGETS | Per-target write strobe |
| dsRead | output | N_TARGETS | Per-target read strobe |
| dsWait | input | N_TARGETS | Per-target waitrequest |
| dsRdValid | input | N_TARGETS | Per-target read data valid |
| dsRdata | input | N_TARGETS*DATA_W | Per-target read data lanes, target n at bits [n*DATA_W +: DATA_W] |

## Verification
Two things can land in the same cycle: acceptance of a read address, and acceptance of the write address/data halves. The bench provokes this by raising `arValid`, `awValid` and `wValid` together on one idle cycle. It judges the outcome in three ways:
- the ready levels seen in that cycle;
- the order and content of the commands recorded by the target models;
- the fact that no write half is taken while the read is still outstanding.

The sweep over all 32 region codes covers every mapped region and every unmapped one, in both address modes at once. Waitrequest lengths, address/data orderings and response back-pressure vary along the sweep.

// File: rtl/csr_bridge_pkg.sv
package csr_bridge_pkg;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_DECERR = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR,
    ST_RD,
    ST_RDWAIT,
    ST_BRSP,
    ST_RRSP
  } bridgeState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capAw;     // load address register from write channel
    logic capW;      // load write data and strobes
    logic capAr;     // load address register from read channel, clear read data
    logic capRdata;  // load read data from the selected target lane
    logic reqRead;   // drive read strobe of the selected target
    logic reqWrite;  // drive write strobe of the selected target
  } ctlStrobe_t;

endpackage

// File: rtl/csr_bridge_dpath.sv
module csr_bridge_dpath
  import csr_bridge_pkg::*;
#(
  parameter int ADDR_W    = 26,
  parameter int OFF_W     = 21,
  parameter int N_TARGETS = 25,
  parameter int DATA_W    = 32,
  parameter bit BYTE_MODE = 1'b0
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctlStrobe_t                    strobes,
  input  logic [ADDR_W-1:0]             awAddr,
  input  logic [ADDR_W-1:0]             arAddr,
  input  logic [DATA_W-1:0]             wData,
  input  logic [DATA_W/8-1:0]           wStrb,
  input  logic [N_TARGETS-1:0]          dsWait,
  input  logic [N_TARGETS-1:0]          dsRdValid,
  input  logic [N_TARGETS*DATA_W-1:0]   dsRdata,
  output logic [OFF_W-1:0]              dsAddr,
  output logic [DATA_W-1:0]             dsWdata,
  output logic [DATA_W/8-1:0]           dsBe,
  output logic [N_TARGETS-1:0]          dsWrite,
  output logic [N_TARGETS-1:0]          dsRead,
  output logic [DATA_W-1:0]             rData,
  output logic                          regionOk,
  output logic                          selWait,
  output logic                          selRdValid
);

  localparam int STRB_W = DATA_W / 8;
  localparam int SHIFT  = $clog2(STRB_W);
  localparam int REG_W  = ADDR_W - OFF_W;

  logic [ADDR_W-1:0]    addrQ;
  logic [DATA_W-1:0]    dataQ;
  logic [STRB_W-1:0]    strbQ;
  logic [DATA_W-1:0]    rdataQ;
  logic [REG_W-1:0]     region;
  logic [N_TARGETS-1:0] selVec;
  logic [DATA_W-1:0]    laneSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      dataQ  <= '0;
      strbQ  <= '0;
      rdataQ <= '0;
    end else begin
      if (strobes.capAw) addrQ <= awAddr;
      if (strobes.capAr) begin
        addrQ  <= arAddr;
        rdataQ <= '0;
      end
      if (strobes.capW) begin
        dataQ <= wData;
        strbQ <= wStrb;
      end
      if (strobes.capRdata) rdataQ <= laneSel;
    end
  end

  // region decode on the registered address
  assign region   = addrQ[ADDR_W-1:OFF_W];
  assign regionOk = (int'(region) < N_TARGETS);

  for (genvar i = 0; i < N_TARGETS; i++) begin : g_sel
    assign selVec[i] = (int'(region) == i);
  end

  always_comb begin
    laneSel = '0;
    for (int i = 0; i < N_TARGETS; i++) begin
      if (selVec[i]) laneSel = laneSel | dsRdata[i*DATA_W +: DATA_W];
    end
  end

  assign dsRead     = selVec & {N_TARGETS{strobes.reqRead}};
  assign dsWrite    = selVec & {N_TARGETS{strobes.reqWrite}};
  assign selWait    = |(selVec & dsWait);
  assign selRdValid = |(selVec & dsRdValid);
  assign dsWdata    = dataQ;
  assign rData      = rdataQ;

  if (BYTE_MODE) begin : g_byte
    assign dsAddr = {addrQ[OFF_W-1:SHIFT], {SHIFT{1'b0}}};
    assign dsBe   = strobes.reqWrite ? strbQ : {STRB_W{1'b1}};
  end else begin : g_word
    assign dsAddr = {{SHIFT{1'b0}}, addrQ[OFF_W-1:SHIFT]};
    assign dsBe   = {STRB_W{1'b1}};
  end

endmodule

// File: rtl/csr_bridge_ctrl.sv
module csr_bridge_ctrl
  import csr_bridge_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       awValid,
  output logic       awReady,
  input  logic       wValid,
  output logic       wReady,
  input  logic       arValid,
  output logic       arReady,
  output logic [1:0] bResp,
  output logic       bValid,
  input  logic       bReady,
  output logic [1:0] rResp,
  output logic       rValid,
  input  logic       rReady,
  input  logic       regionOk,
  input  logic       selWait,
  input  logic       selRdValid,
  output ctlStrobe_t strobes
);

  bridgeState_t state, nxt;
  logic awHeld, wHeld, errQ, errNxt;
  logic isIdle, nothingHeld, readWins;

  assign isIdle      = (state == ST_IDLE);
  assign nothingHeld = !awHeld && !wHeld;
  assign arReady     = isIdle && nothingHeld;
  assign readWins    = arReady && arValid;
  assign awReady     = isIdle && !awHeld && !readWins;
  assign wReady      = isIdle && !wHeld && !readWins;

  always_comb begin
    strobes          = '0;
    strobes.capAw    = awValid && awReady;
    strobes.capW     = wValid && wReady;
    strobes.capAr    = readWins;
    strobes.reqRead  = (state == ST_RD) && regionOk;
    strobes.reqWrite = (state == ST_WR) && regionOk;
    strobes.capRdata = (state == ST_RDWAIT) && selRdValid;
  end

  always_comb begin
    nxt    = state;
    errNxt = errQ;
    unique case (state)
      ST_IDLE: begin
        if (readWins)             nxt = ST_RD;
        else if (awHeld && wHeld) nxt = ST_WR;
      end
      ST_WR: begin
        if (!regionOk) begin
          nxt = ST_BRSP; errNxt = 1'b1;
        end else if (!selWait) begin
          nxt = ST_BRSP; errNxt = 1'b0;
        end
      end
      ST_RD: begin
        if (!regionOk) begin
          nxt = ST_RRSP; errNxt = 1'b1;
        end else if (!selWait) begin
          nxt = ST_RDWAIT; errNxt = 1'b0;
        end
      end
      ST_RDWAIT: if (selRdValid) nxt = ST_RRSP;
      ST_BRSP:   if (bReady)     nxt = ST_IDLE;
      ST_RRSP:   if (rReady)     nxt = ST_IDLE;
      default:                   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      awHeld <= 1'b0;
      wHeld  <= 1'b0;
      errQ   <= 1'b0;
    end else begin
      state <= nxt;
      errQ  <= errNxt;
      if (strobes.capAw) awHeld <= 1'b1;
      if (strobes.capW)  wHeld  <= 1'b1;
      if (state == ST_WR && nxt != ST_WR) begin
        awHeld <= 1'b0;
        wHeld  <= 1'b0;
      end
    end
  end

  assign bValid = (state == ST_BRSP);
  assign rValid = (state == ST_RRSP);
  assign bResp  = errQ ? RESP_DECERR : RESP_OKAY;
  assign rResp  = errQ ? RESP_DECERR : RESP_OKAY;

endmodule

// File: rtl/axil_csr_bridge.sv
module axil_csr_bridge
  import csr_bridge_pkg::*;
#(
  parameter int ADDR_W    = 26,
  parameter int OFF_W     = 21,
  parameter int N_TARGETS = 25,
  parameter int DATA_W    = 32,
  parameter bit BYTE_MODE = 1'b0
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [ADDR_W-1:0]           awAddr,
  input  logic                        awValid,
  output logic                        awReady,
  input  logic [DATA_W-1:0]           wData,
  input  logic [DATA_W/8-1:0]         wStrb,
  input  logic                        wValid,
  output logic                        wReady,
  output logic [1:0]                  bResp,
  output logic                        bValid,
  input  logic                        bReady,
  input  logic [ADDR_W-1:0]           arAddr,
  input  logic                        arValid,
  output logic                        arReady,
  output logic [DATA_W-1:0]           rData,
  output logic [1:0]                  rResp,
  output logic                        rValid,
  input  logic                        rReady,
  output logic [OFF_W-1:0]            dsAddr,
  output logic [DATA_W-1:0]           dsWdata,
  output logic [DATA_W/8-1:0]         dsBe,
  output logic [N_TARGETS-1:0]        dsWrite,
  output logic [N_TARGETS-1:0]        dsRead,
  input  logic [N_TARGETS-1:0]        dsWait,
  input  logic [N_TARGETS-1:0]        dsRdValid,
  input  logic [N_TARGETS*DATA_W-1:0] dsRdata
);

  ctlStrobe_t strobes;
  logic regionOk, selWait, selRdValid;

  csr_bridge_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .awValid(awValid), .awReady(awReady),
    .wValid(wValid), .wReady(wReady),
    .arValid(arValid), .arReady(arReady),
    .bResp(bResp), .bValid(bValid), .bReady(bReady),
    .rResp(rResp), .rValid(rValid), .rReady(rReady),
    .regionOk(regionOk), .selWait(selWait), .selRdValid(selRdValid),
    .strobes(strobes)
  );

  csr_bridge_dpath #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .N_TARGETS(N_TARGETS),
    .DATA_W(DATA_W), .BYTE_MODE(BYTE_MODE)
  ) uDpath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .awAddr(awAddr), .arAddr(arAddr), .wData(wData), .wStrb(wStrb),
    .dsWait(dsWait), .dsRdValid(dsRdValid), .dsRdata(dsRdata),
    .dsAddr(dsAddr), .dsWdata(dsWdata), .dsBe(dsBe),
    .dsWrite(dsWrite), .dsRead(dsRead), .rData(rData),
    .regionOk(regionOk), .selWait(selWait), .selRdValid(selRdValid)
  );

endmodule

// File: rtl/axil_csr_bridge_chk.sv
module axil_csr_bridge_chk #(
  parameter int OFF_W     = 21,
  parameter int N_TARGETS = 25,
  parameter int DATA_W    = 32
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   awReady,
  input logic                   wReady,
  input logic                   arValid,
  input logic                   arReady,
  input logic [1:0]             bResp,
  input logic                   bValid,
  input logic                   bReady,
  input logic [DATA_W-1:0]      rData,
  input logic [1:0]             rResp,
  input logic                   rValid,
  input logic                   rReady,
  input logic [OFF_W-1:0]       dsAddr,
  input logic [DATA_W-1:0]      dsWdata,
  input logic [DATA_W/8-1:0]    dsBe,
  input logic [N_TARGETS-1:0]   dsWrite,
  input logic [N_TARGETS-1:0]   dsRead,
  input logic [N_TARGETS-1:0]   dsWait
);

  p_single_strobe_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({dsRead, dsWrite}));

  p_decerr_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rValid && rResp == 2'b11) |-> (rData == '0));

  p_quiet_while_resp_r7: assert property (@(posedge clk) disable iff (!rstN)
    (bValid || rValid) |-> !(|{dsRead, dsWrite}));

  p_one_resp_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(bValid && rValid));

  p_hold_req_r8: assert property (@(posedge clk) disable iff (!rstN)
    (|((dsRead | dsWrite) & dsWait)) |=>
      ($stable(dsRead) && $stable(dsWrite) && $stable(dsAddr) &&
       $stable(dsBe) && $stable(dsWdata)));

  p_read_first_r11: assert property (@(posedge clk) disable iff (!rstN)
    (arValid && arReady) |-> !(awReady || wReady));

  p_b_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (bValid && !bReady) |=> (bValid && $stable(bResp)));

  p_r_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (rValid && !rReady) |=> (rValid && $stable(rData) && $stable(rResp)));

endmodule

bind axil_csr_bridge axil_csr_bridge_chk #(
  .OFF_W(OFF_W), .N_TARGETS(N_TARGETS), .DATA_W(DATA_W)
) uChk (
  .clk(clk), .rstN(rstN), .awReady(awReady), .wReady(wReady),
  .arValid(arValid), .arReady(arReady), .bResp(bResp), .bValid(bValid),
  .bReady(bReady), .rData(rData), .rResp(rResp), .rValid(rValid),
  .rReady(rReady), .dsAddr(dsAddr), .dsWdata(dsWdata), .dsBe(dsBe),
  .dsWrite(dsWrite), .dsRead(dsRead), .dsWait(dsWait)
);

// File: tb/axil_csr_bridge_test.sv
module csr_target_model #(
  parameter int N     = 25,
  parameter int OFF_W = 21
) (
  input  logic              clk,
  input  logic              rstN,
  input  int                waitTarget,
  input  logic [N-1:0]      dsRead,
  input  logic [N-1:0]      dsWrite,
  input  logic [OFF_W-1:0]  dsAddr,
  input  logic [31:0]       dsWdata,
  input  logic [3:0]        dsBe,
  output logic [N-1:0]      dsWait,
  output logic [N-1:0]      dsRdValid,
  output logic [N*32-1:0]   dsRdata,
  output int                count,
  output int                lastIdx,
  output logic              lastWr,
  output logic [OFF_W-1:0]  lastAddr,
  output logic [3:0]        lastBe,
  output logic [31:0]       lastData,
  output logic              badStrobe,
  output logic              unstable
);
  int reqAge;
  logic anyReq, accept;
  logic [N-1:0] prevRead, prevWrite;
  logic [OFF_W-1:0] prevAddr;

  assign anyReq = (|dsRead) || (|dsWrite);
  assign accept = anyReq && (reqAge >= waitTarget);
  assign dsWait = {N{anyReq && (reqAge < waitTarget)}};

  for (genvar i = 0; i < N; i++) begin : g_lane
    assign dsRdata[i*32 +: 32] = 32'hA500_0000 ^ (i * 32'h0001_0203);
  end

  function automatic int whichIdx(input logic [N-1:0] v);
    int k = -1;
    for (int i = 0; i < N; i++) if (v[i]) k = i;
    return k;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      reqAge <= 0; count <= 0; lastIdx <= -1; lastWr <= 0;
      lastAddr <= '0; lastBe <= '0; lastData <= '0;
      badStrobe <= 0; unstable <= 0; dsRdValid <= '0;
      prevRead <= '0; prevWrite <= '0; prevAddr <= '0;
    end else begin
      dsRdValid <= accept ? dsRead : '0;
      reqAge <= (anyReq && !accept) ? reqAge + 1 : 0;
      if (anyReq && $countones({dsRead, dsWrite}) != 1) badStrobe <= 1;
      if (anyReq && reqAge > 0 &&
          (dsRead != prevRead || dsWrite != prevWrite || dsAddr != prevAddr)) unstable <= 1;
      prevRead <= dsRead; prevWrite <= dsWrite; prevAddr <= dsAddr;
      if (accept) begin
        count    <= count + 1;
        lastWr   <= |dsWrite;
        lastIdx  <= whichIdx(dsRead | dsWrite);
        lastAddr <= dsAddr;
        lastBe   <= dsBe;
        lastData <= dsWdata;
      end
    end
  end
endmodule

module axil_csr_bridge_test;
  localparam int N = 25;
  localparam int OFF_W = 21;

  logic clk = 0;
  logic rstN = 0;
  always #5 clk = ~clk;

  logic [25:0] awAddr = '0, arAddr = '0;
  logic awValid = 0, wValid = 0, arValid = 0, bReady = 0, rReady = 0;
  logic [31:0] wData = '0;
  logic [3:0]  wStrb = '0;
  int waitTarget = 0;

  logic awReady, wReady, arReady, bValid, rValid;
  logic [1:0] bResp, rResp;
  logic [31:0] rData;
  logic awReadyB, wReadyB, arReadyB, bValidB, rValidB;
  logic [1:0] bRespB, rRespB;
  logic [31:0] rDataB;

  logic [OFF_W-1:0] dsAddrW, dsAddrB;
  logic [31:0] dsWdataW, dsWdataB;
  logic [3:0] dsBeW, dsBeB;
  logic [N-1:0] dsWriteW, dsReadW, dsWaitW, dsRdValidW;
  logic [N-1:0] dsWriteB, dsReadB, dsWaitB, dsRdValidB;
  logic [N*32-1:0] dsRdataW, dsRdataB;

  int cntW, idxW, cntB, idxB;
  logic wrW, wrB, badW, badB, unsW, unsB;
  logic [OFF_W-1:0] addrW, addrB;
  logic [3:0] beW, beB;
  logic [31:0] dataW, dataB;

  axil_csr_bridge #(.BYTE_MODE(1'b0)) uut (
    .clk(clk), .rstN(rstN), .awAddr(awAddr), .awValid(awValid), .awReady(awReady),
    .wData(wData), .wStrb(wStrb), .wValid(wValid), .wReady(wReady),
    .bResp(bResp), .bValid(bValid), .bReady(bReady),
    .arAddr(arAddr), .arValid(arValid), .arReady(arReady),
    .rData(rData), .rResp(rResp), .rValid(rValid), .rReady(rReady),
    .dsAddr(dsAddrW), .dsWdata(dsWdataW), .dsBe(dsBeW), .dsWrite(dsWriteW),
    .dsRead(dsReadW), .dsWait(dsWaitW), .dsRdValid(dsRdValidW), .dsRdata(dsRdataW));

  axil_csr_bridge #(.BYTE_MODE(1'b1)) uutByte (
    .clk(clk), .rstN(rstN), .awAddr(awAddr), .awValid(awValid), .awReady(awReadyB),
    .wData(wData), .wStrb(wStrb), .wValid(wValid), .wReady(wReadyB),
    .bResp(bRespB), .bValid(bValidB), .bReady(bReady),
    .arAddr(arAddr), .arValid(arValid), .arReady(arReadyB),
    .rData(rDataB), .rResp(rRespB), .rValid(rValidB), .rReady(rReady),
    .dsAddr(dsAddrB), .dsWdata(dsWdataB), .dsBe(dsBeB), .dsWrite(dsWriteB),
    .dsRead(dsReadB), .dsWait(dsWaitB), .dsRdValid(dsRdValidB), .dsRdata(dsRdataB));

  csr_target_model #(.N(N), .OFF_W(OFF_W)) mW (
    .clk(clk), .rstN(rstN), .waitTarget(waitTarget), .dsRead(dsReadW), .dsWrite(dsWriteW),
    .dsAddr(dsAddrW), .dsWdata(dsWdataW), .dsBe(dsBeW), .dsWait(dsWaitW),
    .dsRdValid(dsRdValidW), .dsRdata(dsRdataW), .count(cntW), .lastIdx(idxW),
    .lastWr(wrW), .lastAddr(addrW), .lastBe(beW), .lastData(dataW),
    .badStrobe(badW), .unstable(unsW));

  csr_target_model #(.N(N), .OFF_W(OFF_W)) mB (
    .clk(clk), .rstN(rstN), .waitTarget(waitTarget), .dsRead(dsReadB), .dsWrite(dsWriteB),
    .dsAddr(dsAddrB), .dsWdata(dsWdataB), .dsBe(dsBeB), .dsWait(dsWaitB),
    .dsRdValid(dsRdValidB), .dsRdata(dsRdataB), .count(cntB), .lastIdx(idxB),
    .lastWr(wrB), .lastAddr(addrB), .lastBe(beB), .lastData(dataB),
    .badStrobe(badB), .unstable(unsB));

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] lanePattern(input int i);
    return 32'hA500_0000 ^ (i * 32'h0001_0203);
  endfunction

  // order: 0 address and data together, 1 data first, 2 address first
  task automatic axiWrite(input logic [25:0] a, input logic [31:0] d, input logic [3:0] s,
                          input int order, input bit holdB);
    @(negedge clk);
    if (order == 0) begin
      awAddr = a; awValid = 1; wData = d; wStrb = s; wValid = 1;
      while (!(awReady && wReady)) @(negedge clk);
      @(negedge clk); awValid = 0; wValid = 0;
    end else if (order == 1) begin
      wData = d; wStrb = s; wValid = 1;
      while (!wReady) @(negedge clk);
      @(negedge clk); wValid = 0;
      @(negedge clk); awAddr = a; awValid = 1;
      while (!awReady) @(negedge clk);
      @(negedge clk); awValid = 0;
    end else begin
      awAddr = a; awValid = 1;
      while (!awReady) @(negedge clk);
      @(negedge clk); awValid = 0;
      @(negedge clk); wData = d; wStrb = s; wValid = 1;
      while (!wReady) @(negedge clk);
      @(negedge clk); wValid = 0;
    end
    while (!bValid) @(negedge clk);
    if (holdB) begin
      logic [1:0] firstResp = bResp;
      repeat (2) @(negedge clk);
      check(bValid && bResp == firstResp, "R12 bValid held under back-pressure",
            {30'd0, bResp}, {30'd0, firstResp});
    end
    bReady = 1;
    @(negedge clk);
    bReady = 0;
  endtask

  task automatic axiRead(input logic [25:0] a, input bit holdR);
    @(negedge clk);
    arAddr = a; arValid = 1;
    while (!arReady) @(negedge clk);
    @(negedge clk); arValid = 0;
    while (!rValid) @(negedge clk);
    if (holdR) begin
      logic [31:0] firstData = rData;
      repeat (2) @(negedge clk);
      check(rValid && rData == firstData, "R12 rValid held under back-pressure", rData, firstData);
    end
  endtask

  task automatic finishRead();
    rReady = 1;
    @(negedge clk);
    rReady = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // reset state, R7: idle, nothing pending
    check(!bValid && !rValid, "R7 reset no response pending", {30'd0, bValid, rValid}, 32'd0);
    check(dsReadW == '0 && dsWriteW == '0, "R1 reset no strobe", 32'(dsReadW | dsWriteW), 32'd0);
    check(arReady && awReady && wReady, "R7 reset ready levels",
          {29'd0, arReady, awReady, wReady}, 32'd7);

    for (int r = 0; r < 32; r++) begin
      logic [25:0] a;
      logic [31:0] d;
      logic [3:0]  s;
      int c0W, c0B;
      logic [OFF_W-1:0] expWordAddr, expByteAddr;
      a = 26'((r << 21) | ((r * 148 + 32'h100) & 32'h1F_FFFC) | (r % 4));
      d = 32'hDEAD_0000 ^ (r * 32'h0101_0101);
      s = 4'((r % 15) + 1);
      waitTarget = r % 3;
      expWordAddr = OFF_W'(a[20:2]);
      expByteAddr = {a[20:2], 2'b00};
      c0W = cntW; c0B = cntB;

      axiWrite(a, d, s, r % 3, r % 2 == 1);
      if (r < 25) begin
        check(bResp == 2'b00 && bRespB == 2'b00, "R10 write OKAY", {28'd0, bResp, bRespB}, 32'd0);
        check(cntW == c0W + 1 && cntB == c0B + 1, "R1 one write command", cntW - c0W, 32'd1);
        check(idxW == r && idxB == r, "R5 write target index", idxW, r);
        check(wrW && dataW == d, "R7 write issued with captured data", dataW, d);
        check(addrW == expWordAddr, "R2/R4 word write address", 32'(addrW), 32'(expWordAddr));
        check(beW == 4'hF, "R2 word write enables full", 32'(beW), 32'hF);
        check(addrB == expByteAddr, "R3/R4 byte write address", 32'(addrB), 32'(expByteAddr));
        check(beB == s, "R3 byte write enables from strobes", 32'(beB), 32'(s));
      end else begin
        check(bResp == 2'b11 && bRespB == 2'b11, "R6 write DECERR", {28'd0, bResp, bRespB}, 32'hF);
        check(cntW == c0W && cntB == c0B, "R6 no write forwarded", cntW - c0W, 32'd0);
      end

      c0W = cntW; c0B = cntB;
      axiRead(a, r % 2 == 0);
      if (r < 25) begin
        check(rData == lanePattern(r), "R9 read data word mode", rData, lanePattern(r));
        check(rDataB == lanePattern(r), "R9 read data byte mode", rDataB, lanePattern(r));
        check(rResp == 2'b00 && rRespB == 2'b00, "R9 read OKAY", {28'd0, rResp, rRespB}, 32'd0);
        check(cntW == c0W + 1 && !wrW && idxW == r, "R1/R5 one read command", idxW, r);
        check(addrW == expWordAddr, "R2/R4 word read address", 32'(addrW), 32'(expWordAddr));
        check(addrB == expByteAddr && beB == 4'hF, "R3 byte read address and enables",
              32'(addrB), 32'(expByteAddr));
      end else begin
        check(rData == 32'd0 && rDataB == 32'd0, "R6 DECERR read data zero", rData, 32'd0);
        check(rResp == 2'b11 && rRespB == 2'b11, "R6 read DECERR", {28'd0, rResp, rRespB}, 32'hF);
        check(cntW == c0W && cntB == c0B, "R6 no read forwarded", cntW - c0W, 32'd0);
      end
      finishRead();
    end

    // R11: read and write offered in the same idle cycle
    begin
      int c0;
      logic sawWrAccept;
      waitTarget = 1;
      c0 = cntW;
      sawWrAccept = 0;
      @(negedge clk);
      arAddr = 26'h060_0040; arValid = 1;
      awAddr = 26'h140_0080; awValid = 1; wData = 32'h1234_5678; wStrb = 4'h3; wValid = 1;
      #1;
      check(arReady && !awReady && !wReady, "R11 read taken first",
            {29'd0, arReady, awReady, wReady}, 32'd4);
      @(negedge clk);
      arValid = 0;
      while (!rValid) begin
        sawWrAccept = sawWrAccept | awReady | wReady;
        @(negedge clk);
      end
      check(!sawWrAccept, "R7 no write half taken during read", 32'(sawWrAccept), 32'd0);
      check(rData == lanePattern(3) && cntW == c0 + 1 && !wrW, "R11 read completes first",
            rData, lanePattern(3));
      finishRead();
      while (!(awReady && wReady)) @(negedge clk);
      @(negedge clk);
      awValid = 0; wValid = 0;
      while (!bValid) @(negedge clk);
      check(bResp == 2'b00 && cntW == c0 + 2 && wrW && idxW == 10, "R11 write follows read",
            idxW, 32'd10);
      check(beB == 4'h3 && beW == 4'hF, "R2/R3 partial strobe per mode",
            {24'd0, beW, beB}, 32'hF3);
      bReady = 1;
      @(negedge clk);
      bReady = 0;
    end

    check(!badW && !badB, "R1 never more than one strobe", {30'd0, badW, badB}, 32'd0);
    check(!unsW && !unsB, "R8 request stable under waitrequest", {30'd0, unsW, unsB}, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule